// File: doc/BRIEF.md
# Shared Multi-CPU Interrupt Distributor

This block collects level-sensitive interrupt lines and hands each one to a chosen subset of up to four CPUs. Software configures it through a small register bus with two address spaces. The first is a shared space that holds the per-source global enables, the per-source CPU routing and a read-only control word. The second is a per-CPU space, and the issuing CPU is identified by a sideband field on the bus. Enables and masks are changed by writing a source *number* to a dedicated set register or clear register. No read-modify-write of a bitmap is needed, so two CPUs can never overwrite each other's updates.

Each CPU sees one interrupt line, which is raised while at least one source is eligible for it. A source is eligible when its input is high, it is globally enabled, it is routed to that CPU and that CPU has not masked it. The CPU then reads its acknowledge register and gets the lowest-numbered eligible source, or a spurious code when nothing is eligible. One source number is reserved for a banked timer. Each CPU has its own timer line for that number, which is gated only by that CPU's mask and not by the global enable or the routing.

Top module: `irq_distributor`

## Requirements
- R1: After reset all global enables are clear, every maskable source is masked for every CPU, all routing fields read 0, every `cpu_irq` bit is low and every acknowledge read returns 1023.
- R2: A shared-space write of value n to offset 0x30 sets the global enable of source n, and a write of n to offset 0x34 clears it. Values n at or above the source count change nothing.
- R3: A per-CPU write of value n to offset 0x48 masks source n for the CPU named by `reg_cpu`, and a write of n to offset 0x4C unmasks it. Masks of other CPUs are unaffected. Values n of 28 or more are ignored, and sources 28 and above can never be masked.
- R4: Shared offset 0x100 + 4*n is the routing register of source n. Bits [3:0] are stored and read back, and bit c set delivers the source to CPU c.
- R5: A shared-space read of offset 0x00 returns the source count in bits [11:2], with the other bits 0.
- R6: A per-CPU read of offset 0x44 returns in bits [9:0] the lowest-numbered source eligible for that CPU, or 1023 if none is eligible. Reading has no side effect.
- R7: Source 5 is the banked timer. It is eligible for CPU c exactly when `timer_in[c]` is high and CPU c has not masked source 5. The global enable and routing of source 5 have no effect, and neither does `src_in[5]`.
- R8: Sources are level-sensitive. A source is pending only while its input is high, and it stops being eligible as soon as the input drops.
- R9: `cpu_irq[c]` is high exactly when an acknowledge read by CPU c would return a value other than 1023.
- R10: Read data appears on `reg_rdata` with `reg_rvalid` high in the cycle after `reg_rd` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NUM_SRC | Level-sensitive shared source lines (bit 5 unused) |
| timer_in | input | NUM_CPUS | Banked timer line, one per CPU |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_global | input | 1 | 1 selects the shared space, 0 the per-CPU space |
| reg_cpu | input | CPU_W | Identity of the issuing CPU |
| reg_addr | input | 12 | Byte offset within the selected space |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| cpu_irq | output | NUM_CPUS | Per-CPU interrupt request |

## Verification
The banked timer and a routed shared source can be eligible for the same CPU in the same cycle, and both then contend for that CPU's acknowledge code. The bench raises two CPUs' timer lines and then also raises a lower-numbered shared source routed to all CPUs. It judges every CPU's acknowledge value and interrupt line against an arithmetic model of enables, masks and routing. That model expects the shared source to win everywhere while it is enabled, and the timer to win only on unmasked timer CPUs once the shared source is disabled. Every source number is swept on every CPU, and per-CPU masking is swept across the whole maskable range, with the sweep also crossing into the unmaskable numbers.

// File: rtl/irqd_pkg.sv
// Package irqd_pkg
// Shared constants for the interrupt distributor: register offsets of the
// shared and per-CPU spaces, the acknowledge code width and the spurious code.
package irqd_pkg;
    localparam int REG_AW = 12;
    localparam int REG_DW = 32;
    localparam int ID_W   = 10;

    localparam logic [ID_W-1:0] NO_SOURCE = 10'h3FF;

    // Shared space
    localparam logic [REG_AW-1:0] G_CTRL      = 12'h000;
    localparam logic [REG_AW-1:0] G_EN_SET    = 12'h030;
    localparam logic [REG_AW-1:0] G_EN_CLR    = 12'h034;
    localparam int                G_ROUTE     = 'h100;
    localparam int                ROUTE_STEP  = 4;

    // Per-CPU space
    localparam logic [REG_AW-1:0] P_ACK       = 12'h044;
    localparam logic [REG_AW-1:0] P_MASK_SET  = 12'h048;
    localparam logic [REG_AW-1:0] P_MASK_CLR  = 12'h04C;
endpackage

// File: rtl/irqd_regs.sv
// Module irqd_regs
// Holds the configuration state: global enable per source, per-CPU mask for
// the low-numbered sources, and a CPU routing field per source. Enables and
// masks are updated by source number through set/clear offsets.
// Assumes a single write per cycle; out-of-range numbers are dropped.
module irqd_regs
    import irqd_pkg::*;
#(
    parameter int NUM_SRC      = 32,
    parameter int NUM_CPUS     = 4,
    parameter int NUM_MASKABLE = 28,
    localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int MSK_W = (NUM_MASKABLE > 1) ? $clog2(NUM_MASKABLE) : 1
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     wr_en,
    input  logic                                     wr_global,
    input  logic [CPU_W-1:0]                         wr_cpu,
    input  logic [REG_AW-1:0]                        wr_addr,
    input  logic [REG_DW-1:0]                        wr_data,
    output logic [NUM_SRC-1:0]                       enable_o,
    output logic [NUM_CPUS-1:0][NUM_MASKABLE-1:0]    mask_o,
    output logic [NUM_SRC-1:0][NUM_CPUS-1:0]         route_o
);
    logic [NUM_SRC-1:0]                    en_q;
    logic [NUM_CPUS-1:0][NUM_MASKABLE-1:0] mask_q;
    logic [NUM_SRC-1:0][NUM_CPUS-1:0]      route_q;

    logic             src_ok, msk_ok;
    logic [SRC_W-1:0] src_idx;
    logic [MSK_W-1:0] msk_idx;
    logic             en_set_hit, en_clr_hit, msk_set_hit, msk_clr_hit;

    // Decode the number-indexed set/clear writes.
    always_comb begin
        src_ok      = wr_data < REG_DW'(NUM_SRC);
        msk_ok      = wr_data < REG_DW'(NUM_MASKABLE);
        src_idx     = wr_data[SRC_W-1:0];
        msk_idx     = wr_data[MSK_W-1:0];
        en_set_hit  = wr_en &&  wr_global && wr_addr == G_EN_SET   && src_ok;
        en_clr_hit  = wr_en &&  wr_global && wr_addr == G_EN_CLR   && src_ok;
        msk_set_hit = wr_en && !wr_global && wr_addr == P_MASK_SET && msk_ok;
        msk_clr_hit = wr_en && !wr_global && wr_addr == P_MASK_CLR && msk_ok;
    end

    // Global enable bits, set or cleared by source number.
    always_ff @(posedge clk) begin
        if (!rst_n)          en_q <= '0;
        else if (en_set_hit) en_q[src_idx] <= 1'b1;
        else if (en_clr_hit) en_q[src_idx] <= 1'b0;
    end

    // Per-CPU mask bits, updated only for the CPU issuing the write.
    always_ff @(posedge clk) begin
        if (!rst_n)           mask_q <= '1;
        else if (msk_set_hit) mask_q[wr_cpu][msk_idx] <= 1'b1;
        else if (msk_clr_hit) mask_q[wr_cpu][msk_idx] <= 1'b0;
    end

    // Routing field of each source, written at its own offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= '0;
        end else begin
            for (int n = 0; n < NUM_SRC; n++) begin
                if (wr_en && wr_global && wr_addr == REG_AW'(G_ROUTE + ROUTE_STEP * n))
                    route_q[n] <= wr_data[NUM_CPUS-1:0];
            end
        end
    end

    assign enable_o = en_q;
    assign mask_o   = mask_q;
    assign route_o  = route_q;

    // R2: a set write leaves the numbered enable high
    a_r2_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_global && wr_addr == G_EN_SET && wr_data < REG_DW'(NUM_SRC))
        |=> en_q[$past(src_idx)]);

    // R2: a clear write leaves the numbered enable low
    a_r2_enable_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_global && wr_addr == G_EN_CLR && wr_data < REG_DW'(NUM_SRC))
        |=> !en_q[$past(src_idx)]);

    // R3: a mask write sets the bit of the issuing CPU
    a_r3_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_global && wr_addr == P_MASK_SET && wr_data < REG_DW'(NUM_MASKABLE))
        |=> mask_q[$past(wr_cpu)][$past(msk_idx)]);

    // R3: an unmask write clears the bit of the issuing CPU
    a_r3_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_global && wr_addr == P_MASK_CLR && wr_data < REG_DW'(NUM_MASKABLE))
        |=> !mask_q[$past(wr_cpu)][$past(msk_idx)]);
endmodule

// File: rtl/irqd_select.sv
// Module irqd_select
// One instance per CPU. Forms the eligible vector for that CPU from the
// source lines, enables, routing column and mask row, then picks the lowest
// eligible number. The banked timer number uses this CPU's own timer line
// and ignores enable and routing. Purely combinational apart from checks.
module irqd_select
    import irqd_pkg::*;
#(
    parameter int NUM_SRC      = 32,
    parameter int NUM_MASKABLE = 28,
    parameter int TIMER_SRC    = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SRC-1:0]      src_in,
    input  logic                    timer_in,
    input  logic [NUM_SRC-1:0]      enable,
    input  logic [NUM_SRC-1:0]      routed,
    input  logic [NUM_MASKABLE-1:0] masked,
    output logic [ID_W-1:0]         ack_id,
    output logic                    irq_o
);
    logic [NUM_SRC-1:0] elig;
    logic               unused_timer_cfg;

    assign unused_timer_cfg = ^{src_in[TIMER_SRC], enable[TIMER_SRC], routed[TIMER_SRC]};

    // Eligibility of every source for this CPU.
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        logic blocked;
        if (n < NUM_MASKABLE) begin : g_msk
            assign blocked = masked[n];
        end else begin : g_nomsk
            assign blocked = 1'b0;
        end
        if (n == TIMER_SRC) begin : g_tmr
            assign elig[n] = timer_in & ~blocked;
        end else begin : g_shr
            assign elig[n] = src_in[n] & enable[n] & routed[n] & ~blocked;
        end
    end

    // Lowest-numbered eligible source wins, else the spurious code.
    always_comb begin
        ack_id = NO_SOURCE;
        for (int n = NUM_SRC - 1; n >= 0; n--) begin
            if (elig[n]) ack_id = ID_W'(n);
        end
    end

    // Request line of this CPU.
    always_comb irq_o = |elig;

    // R8: with every input low nothing can be requested
    a_r8_level_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (src_in == '0 && !timer_in) |-> (!irq_o && ack_id == NO_SOURCE));
endmodule

// File: rtl/irq_distributor.sv
// Module irq_distributor
// Top of the shared interrupt distributor. Connects the configuration
// registers, one selector per CPU and a registered read port. Shared-space
// and per-CPU accesses are told apart by reg_global; the per-CPU bank is
// chosen by reg_cpu. Reads return data one cycle after the strobe.
module irq_distributor
    import irqd_pkg::*;
#(
    parameter int NUM_SRC      = 32,
    parameter int NUM_CPUS     = 4,
    parameter int NUM_MASKABLE = 28,
    parameter int TIMER_SRC    = 5,
    localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_in,
    input  logic [NUM_CPUS-1:0]  timer_in,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic                 reg_global,
    input  logic [CPU_W-1:0]     reg_cpu,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [REG_DW-1:0]    reg_wdata,
    output logic [REG_DW-1:0]    reg_rdata,
    output logic                 reg_rvalid,
    output logic [NUM_CPUS-1:0]  cpu_irq
);
    localparam logic [NUM_SRC-1:0] TIMER_BIT = NUM_SRC'(1) << TIMER_SRC;

    logic [NUM_SRC-1:0]                    enable;
    logic [NUM_CPUS-1:0][NUM_MASKABLE-1:0] mask;
    logic [NUM_SRC-1:0][NUM_CPUS-1:0]      route;
    logic [NUM_CPUS-1:0][NUM_SRC-1:0]      route_col;
    logic [NUM_CPUS-1:0][ID_W-1:0]         ack_id;
    logic [REG_DW-1:0]                     rd_mux;

    irqd_regs #(
        .NUM_SRC      (NUM_SRC),
        .NUM_CPUS     (NUM_CPUS),
        .NUM_MASKABLE (NUM_MASKABLE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .wr_global (reg_global),
        .wr_cpu    (reg_cpu),
        .wr_addr   (reg_addr),
        .wr_data   (reg_wdata),
        .enable_o  (enable),
        .mask_o    (mask),
        .route_o   (route)
    );

    // One selector per CPU, fed with that CPU's routing column.
    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        for (genvar n = 0; n < NUM_SRC; n++) begin : g_col
            assign route_col[c][n] = route[n][c];
        end

        irqd_select #(
            .NUM_SRC      (NUM_SRC),
            .NUM_MASKABLE (NUM_MASKABLE),
            .TIMER_SRC    (TIMER_SRC)
        ) u_sel (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_in   (src_in),
            .timer_in (timer_in[c]),
            .enable   (enable),
            .routed   (route_col[c]),
            .masked   (mask[c]),
            .ack_id   (ack_id[c]),
            .irq_o    (cpu_irq[c])
        );

        // R7: a request always has a live cause for this CPU
        a_r7_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq[c] |-> (timer_in[c] || (src_in & ~TIMER_BIT) != '0));
    end

    // Read multiplexer over both address spaces.
    always_comb begin
        rd_mux = '0;
        if (reg_global) begin
            if (reg_addr == G_CTRL) rd_mux = REG_DW'(NUM_SRC) << 2;
            for (int n = 0; n < NUM_SRC; n++) begin
                if (reg_addr == REG_AW'(G_ROUTE + ROUTE_STEP * n))
                    rd_mux = REG_DW'(route[n]);
            end
        end else if (reg_addr == P_ACK) begin
            rd_mux = REG_DW'(ack_id[reg_cpu]);
        end
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rvalid <= 1'b0;
            reg_rdata  <= '0;
        end else begin
            reg_rvalid <= reg_rd;
            reg_rdata  <= reg_rd ? rd_mux : '0;
        end
    end

    // R10: every read strobe is answered in the next cycle
    a_r10_read_response: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);

    // R10: no response without a strobe
    a_r10_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rd && rst_n) |=> !reg_rvalid);

    // R6: an acknowledge response is a source number or the spurious code
    a_r6_ack_range: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_global && reg_addr == P_ACK)
        |=> (reg_rdata[ID_W-1:0] == NO_SOURCE || reg_rdata < REG_DW'(NUM_SRC)));
endmodule

// File: tb/irq_distributor_test.sv
module irq_distributor_test;
    localparam int NS = 32;
    localparam int NC = 4;
    localparam int NM = 28;
    localparam int TS = 5;
    localparam int SPUR = 1023;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic [NC-1:0] tmr = '0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0, reg_global = 1'b0;
    logic [1:0]    reg_cpu = '0;
    logic [11:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          reg_rvalid;
    logic [NC-1:0] cpu_irq;

    always #5 clk = ~clk;

    irq_distributor uut (
        .clk(clk), .rst_n(rst_n), .src_in(src), .timer_in(tmr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_global(reg_global),
        .reg_cpu(reg_cpu), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .cpu_irq(cpu_irq)
    );

    // Reference model state
    bit         m_en   [NS];
    bit         m_mask [NC][NM];
    logic [3:0] m_route[NS];

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_ack(input int c);
        for (int n = 0; n < NS; n++) begin
            bit blk;
            bit e;
            blk = (n < NM) ? m_mask[c][n] : 1'b0;
            if (n == TS) e = tmr[c] && !blk;
            else         e = src[n] && m_en[n] && m_route[n][c] && !blk;
            if (e) return n;
        end
        return SPUR;
    endfunction

    task automatic wr(input bit g, input int cpu, input int addr, input int data);
        @(negedge clk);
        reg_wr = 1'b1; reg_global = g; reg_cpu = 2'(cpu);
        reg_addr = 12'(addr); reg_wdata = 32'(data);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input bit g, input int cpu, input int addr, output int data);
        @(negedge clk);
        reg_rd = 1'b1; reg_global = g; reg_cpu = 2'(cpu); reg_addr = 12'(addr);
        @(negedge clk);
        reg_rd = 1'b0;
        data = int'(reg_rdata);
        chk(reg_rvalid == 1'b1, "R10 rvalid", int'(reg_rvalid), 1);
    endtask

    task automatic en_set(input int n);
        wr(1, 0, 'h30, n);
        if (n < NS) m_en[n] = 1;
    endtask
    task automatic en_clr(input int n);
        wr(1, 0, 'h34, n);
        if (n < NS) m_en[n] = 0;
    endtask
    task automatic msk(input int c, input int n);
        wr(0, c, 'h48, n);
        if (n < NM) m_mask[c][n] = 1;
    endtask
    task automatic unmsk(input int c, input int n);
        wr(0, c, 'h4C, n);
        if (n < NM) m_mask[c][n] = 0;
    endtask
    task automatic route(input int n, input int v);
        wr(1, 0, 'h100 + 4 * n, v);
        m_route[n] = 4'(v);
    endtask

    // Compare every CPU's acknowledge value and request line with the model.
    task automatic verify(input string req);
        for (int c = 0; c < NC; c++) begin
            int d;
            int e;
            e = exp_ack(c);
            rd(0, c, 'h44, d);
            chk(d == e, req, d, e);
            chk(cpu_irq[c] == (e != SPUR), "R9 irq line", int'(cpu_irq[c]), int'(e != SPUR));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int d;
        for (int n = 0; n < NS; n++) begin m_en[n] = 0; m_route[n] = '0; end
        for (int c = 0; c < NC; c++) for (int n = 0; n < NM; n++) m_mask[c][n] = 1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(cpu_irq == '0, "R1 irq after reset", int'(cpu_irq), 0);
        verify("R1 ack after reset");
        rd(1, 0, 'h100, d);           chk(d == 0, "R1 route 0 reset", d, 0);
        rd(1, 0, 'h100 + 4 * 31, d);  chk(d == 0, "R1 route 31 reset", d, 0);
        src = 32'h1; en_set(0); route(0, 1);
        verify("R1 masked at reset");
        en_clr(0); route(0, 0); src = '0;

        // R5: control word
        rd(1, 0, 'h00, d);
        chk(d == (NS << 2), "R5 control word", d, NS << 2);

        for (int c = 0; c < NC; c++) for (int n = 0; n < NM; n++) unmsk(c, n);

        // R4 R8 R2: sweep every shared source to every CPU
        for (int n = 0; n < NS; n++) begin
            if (n == TS) continue;
            for (int c = 0; c < NC; c++) begin
                route(n, 1 << c); en_set(n); src = NS'(1) << n;
                verify("R4 routed source");
                src = '0;
                verify("R8 input dropped");
                src = NS'(1) << n; en_clr(n);
                verify("R2 enable cleared");
                src = '0; route(n, 0);
            end
        end

        // R4: routing read-back
        route(7, 9);   rd(1, 0, 'h100 + 28, d);      chk(d == 9,  "R4 readback 7", d, 9);
        route(31, 10); rd(1, 0, 'h100 + 4 * 31, d);  chk(d == 10, "R4 readback 31", d, 10);

        // R6 R3: priority and per-CPU masking sweep
        src = ~(NS'(1) << TS);
        for (int n = 0; n < NS; n++) begin
            if (n == TS) continue;
            en_set(n); route(n, 15);
        end
        verify("R6 lowest wins");
        verify("R6 read has no side effect");
        for (int n = 0; n < NM; n++) begin
            msk(1, n);
            verify("R3 mask sweep");
        end
        msk(1, 28);
        verify("R3 unmaskable source");
        en_clr(32);
        verify("R2 out of range clear ignored");
        en_set(40);
        verify("R2 out of range set ignored");
        for (int n = 0; n < NM; n++) unmsk(1, n);
        verify("R3 unmasked again");

        // R7: banked timer and contention with a shared source
        src = NS'(1) << TS; en_set(TS); route(TS, 15);
        for (int n = 0; n < NS; n++) if (n != TS) en_clr(n);
        verify("R7 shared line 5 ignored");
        tmr = 4'b1010;
        verify("R7 timer per CPU");
        msk(3, TS);
        verify("R7 timer masked on one CPU");
        src = (NS'(1) << TS) | (NS'(1) << 3); en_set(3);
        verify("R7 timer against lower source");
        en_clr(3);
        verify("R7 timer after shared drop");
        en_clr(TS); route(TS, 0);
        verify("R7 enable of timer ignored");
        tmr = '0;
        verify("R8 timer released");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule